// File: doc/BRIEF.md
# Full-Scan Test Sequence Controller

This block drives a complete full-scan test of one scan chain in a circuit under test. On a start pulse it first shifts a repeating 0,0,1,1 flush pattern through the chain and checks that the same stream comes back out, delayed by the chain length. It then applies a short list of combinational test vectors. For each vector the state bits are shifted into the chain, and one normal-mode capture clock follows with the primary inputs applied. The response captured for one vector is shifted out while the next vector is shifted in. A last unload shift empties the final response.

The controller drives the scan-enable line, the serial scan-in bit and the primary inputs. It watches the serial scan-out bit and the primary outputs. Every compared cycle that disagrees with the expected value adds one to a saturating mismatch counter. When the unload finishes, a done flag rises and a pass flag reports whether no mismatch was seen. Vectors and expected responses are computed inside the block from the vector index.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After a start pulse, the first CHAIN_LEN+4 cycles are flush cycles with scan_en high. In flush cycle t (counted from 0), chain_si is 1 when t mod 4 is 2 or 3, and 0 otherwise.
- R2: In flush cycle t with t >= CHAIN_LEN, chain_so is compared with the flush bit of cycle t-CHAIN_LEN. Each disagreeing cycle adds one mismatch, and earlier flush cycles are not compared.
- R3: Vector k (0..NUM_VEC-1) is shifted in over CHAIN_LEN scan_en-high cycles, bit CHAIN_LEN-1 first, so that chain cell i then holds bit i. One capture cycle follows with scan_en low. The state is (5k+3) mod 2^CHAIN_LEN, and during capture pi_drv carries (2k+1) mod 2^PI_W.
- R4: In the capture cycle of vector k, po_obs is compared with the low PO_W bits of the state XOR the zero-extended inputs. A disagreement adds one mismatch.
- R5: The expected response of vector k is (state + zero-extended inputs) mod 2^CHAIN_LEN. It is compared bit by bit, bit CHAIN_LEN-1 first, at chain_so during the shift of vector k+1, or during a final unload of CHAIN_LEN cycles for the last vector. chain_si is 0 during the unload. The shift of vector 0 is not compared.
- R6: A sequence lasts exactly (NUM_VEC+2)·CHAIN_LEN + NUM_VEC + 4 cycles from the first flush cycle to the first cycle with done high. Of these, all but NUM_VEC cycles have scan_en high.
- R7: pi_drv is 0 in every scan_en-high cycle. scan_en is low while idle and while done.
- R8: done is high from the cycle after the unload until the next accepted start. pass is high exactly when done is high and the mismatch count is zero.
- R9: mismatch_cnt is cleared by an accepted start and saturates at 2^CNT_W-1.
- R10: A start pulse while a sequence is running is ignored, and the sequence length is unchanged.
- R11: After reset the block is idle, with scan_en, chain_si, done, pass and mismatch_cnt all 0, and it stays idle until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sequence when idle or done |
| chain_so | input | 1 | Serial output of the scan chain |
| po_obs | input | PO_W | Primary outputs of the circuit under test |
| scan_en | output | 1 | Scan mode select for the chain (1 = shift) |
| chain_si | output | 1 | Serial input bit to the scan chain |
| pi_drv | output | PI_W | Primary inputs to the circuit under test |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Finished with zero mismatches |
| mismatch_cnt | output | CNT_W | Saturating mismatch count |

## Verification
Assertions check the following on every cycle:
- the length of the flush phase;
- that each capture lasts a single cycle;
- that done is entered only from the unload;
- that a start during a running sequence never restarts the flush;
- that the counter saturates and only ever steps by one.

The bench's scenarios alone show that the sequence works end to end against a modelled scan chain. This covers the cycle count, the flush stream, the states and inputs seen at each capture, and the mismatch totals. Those totals come from faults injected only in the flush, only after it, or throughout.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FLUSH,
    PH_SHIFT,
    PH_CAPT,
    PH_UNLOAD,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/scan_vec_table.sv
// Computed vector table: port A gives stimulus and expected outputs, port B the expected response.
module scan_vec_table #(
  parameter int CHAIN_LEN = 4,
  parameter int PI_W      = 2,
  parameter int PO_W      = 2,
  parameter int VW        = 2
) (
  input  logic [VW-1:0]        idx_a,
  input  logic [VW-1:0]        idx_b,
  output logic [CHAIN_LEN-1:0] st_a,
  output logic [PI_W-1:0]      pi_a,
  output logic [PO_W-1:0]      po_a,
  output logic [CHAIN_LEN-1:0] ns_b
);
  localparam logic [31:0] PI_MASK = (32'd1 << PI_W) - 32'd1;

  logic [31:0] sa, pa, sb, pb;

  always_comb begin
    sa   = 32'(idx_a) * 32'd5 + 32'd3;
    pa   = (32'(idx_a) * 32'd2 + 32'd1) & PI_MASK;
    sb   = 32'(idx_b) * 32'd5 + 32'd3;
    pb   = (32'(idx_b) * 32'd2 + 32'd1) & PI_MASK;
    st_a = sa[CHAIN_LEN-1:0];
    pi_a = pa[PI_W-1:0];
    po_a = sa[PO_W-1:0] ^ pa[PO_W-1:0];
    ns_b = sb[CHAIN_LEN-1:0] + pb[CHAIN_LEN-1:0];
  end
endmodule

// File: rtl/scan_mismatch_ctr.sv
module scan_mismatch_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (hit && cnt != CMAX)   cnt <= cnt + 1'b1;
  end

  // R9: once saturated the count stays put until cleared
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == CMAX) |=> (cnt == CMAX));

  // R9: without a clear the count moves by at most one per cycle and never down
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 4,
  parameter int NUM_VEC   = 3,
  parameter int PI_W      = 2,
  parameter int PO_W      = 2,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             chain_so,
  input  logic [PO_W-1:0]  po_obs,
  output logic             scan_en,
  output logic             chain_si,
  output logic [PI_W-1:0]  pi_drv,
  output logic             done,
  output logic             pass,
  output logic [CNT_W-1:0] mismatch_cnt
);
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int CW = $clog2(CHAIN_LEN + 5);
  localparam logic [CW-1:0] FLUSH_LAST = CW'(CHAIN_LEN + 3);
  localparam logic [CW-1:0] SHIFT_LAST = CW'(CHAIN_LEN - 1);
  localparam logic [CW-1:0] CHAIN_CW   = CW'(CHAIN_LEN);
  localparam logic [VW-1:0] VEC_LAST   = VW'(NUM_VEC - 1);

  phase_t        phase_q;
  logic [CW-1:0] cyc_q;
  logic [VW-1:0] vec_q;
  logic          accept;

  assign accept = start && (phase_q == PH_IDLE || phase_q == PH_DONE);

  // phase sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
      vec_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE, PH_DONE: if (accept) begin
          phase_q <= PH_FLUSH;
          cyc_q   <= '0;
          vec_q   <= '0;
        end
        PH_FLUSH: if (cyc_q == FLUSH_LAST) begin
          phase_q <= PH_SHIFT;
          cyc_q   <= '0;
        end else cyc_q <= cyc_q + 1'b1;
        PH_SHIFT: if (cyc_q == SHIFT_LAST) begin
          phase_q <= PH_CAPT;
          cyc_q   <= '0;
        end else cyc_q <= cyc_q + 1'b1;
        PH_CAPT: begin
          cyc_q <= '0;
          if (vec_q == VEC_LAST) phase_q <= PH_UNLOAD;
          else begin
            phase_q <= PH_SHIFT;
            vec_q   <= vec_q + 1'b1;
          end
        end
        PH_UNLOAD: if (cyc_q == SHIFT_LAST) begin
          phase_q <= PH_DONE;
          cyc_q   <= '0;
        end else cyc_q <= cyc_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // table lookup
  logic [VW-1:0]        idx_b;
  logic [CHAIN_LEN-1:0] st_a, ns_b, st_sh, ns_sh;
  logic [PI_W-1:0]      pi_a;
  logic [PO_W-1:0]      po_a;
  logic [CW-1:0]        bit_sel, flush_rel;

  assign idx_b = (phase_q == PH_UNLOAD) ? VEC_LAST : (vec_q - 1'b1);

  scan_vec_table #(
    .CHAIN_LEN(CHAIN_LEN), .PI_W(PI_W), .PO_W(PO_W), .VW(VW)
  ) u_table (
    .idx_a(vec_q), .idx_b(idx_b),
    .st_a(st_a), .pi_a(pi_a), .po_a(po_a), .ns_b(ns_b)
  );

  assign bit_sel   = SHIFT_LAST - cyc_q;
  assign st_sh     = st_a >> bit_sel;
  assign ns_sh     = ns_b >> bit_sel;
  assign flush_rel = cyc_q - CHAIN_CW;

  // output decode from the phase flops
  always_comb begin
    scan_en  = (phase_q == PH_FLUSH) || (phase_q == PH_SHIFT) || (phase_q == PH_UNLOAD);
    chain_si = 1'b0;
    pi_drv   = '0;
    case (phase_q)
      PH_FLUSH: chain_si = cyc_q[1];
      PH_SHIFT: chain_si = st_sh[0];
      PH_CAPT:  pi_drv   = pi_a;
      default:  ;
    endcase
  end

  // response comparison
  logic so_chk, so_exp, po_chk, hit;

  always_comb begin
    so_chk = 1'b0;
    so_exp = 1'b0;
    case (phase_q)
      PH_FLUSH: begin
        so_chk = (cyc_q >= CHAIN_CW);
        so_exp = flush_rel[1];
      end
      PH_SHIFT: begin
        so_chk = (vec_q != '0);
        so_exp = ns_sh[0];
      end
      PH_UNLOAD: begin
        so_chk = 1'b1;
        so_exp = ns_sh[0];
      end
      default: ;
    endcase
    po_chk = (phase_q == PH_CAPT);
    hit    = (so_chk && (chain_so != so_exp)) || (po_chk && (po_obs != po_a));
  end

  scan_mismatch_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(accept), .hit(hit), .cnt(mismatch_cnt)
  );

  assign done = (phase_q == PH_DONE);
  assign pass = done && (mismatch_cnt == '0);

  // R1: vector shifting begins only after the full flush length
  p_flush_len_r1: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SHIFT && vec_q == '0 && cyc_q == '0) |->
      ($past(phase_q) == PH_FLUSH && $past(cyc_q) == FLUSH_LAST));

  // R3: a capture lasts exactly one cycle
  p_single_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CAPT) |=> (phase_q != PH_CAPT));

  // R8: done is reached only from the unload
  p_done_entry_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(phase_q) == PH_UNLOAD));

  // R10: a start while running never restarts the flush
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_SHIFT || phase_q == PH_CAPT || phase_q == PH_UNLOAD) && start)
      |=> (phase_q != PH_FLUSH));
endmodule

// File: tb/scan_cut_model.sv
// Bench model of a circuit under test: one scan chain plus simple combinational logic.
module scan_cut_model #(
  parameter int CHAIN_LEN = 4,
  parameter int PI_W      = 2,
  parameter int PO_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_en,
  input  logic                 si,
  input  logic [PI_W-1:0]      pi,
  input  logic                 flip_so,
  input  logic                 flip_po,
  output logic                 so,
  output logic [PO_W-1:0]      po,
  output logic [CHAIN_LEN-1:0] cells
);
  logic [CHAIN_LEN-1:0] pi_ext;
  logic [PO_W-1:0]      pi_po;

  assign pi_ext = CHAIN_LEN'(pi);
  assign pi_po  = PO_W'(pi);

  always_ff @(posedge clk) begin
    if (rst)          cells <= '0;
    else if (scan_en) cells <= {cells[CHAIN_LEN-2:0], si};
    else              cells <= cells + pi_ext;
  end

  assign so = cells[CHAIN_LEN-1] ^ flip_so;
  assign po = (cells[PO_W-1:0] ^ pi_po) ^ {{(PO_W-1){1'b0}}, flip_po};
endmodule

// File: tb/scan_seq_ctrl_tb.sv
module scan_seq_ctrl_tb;
  localparam int L     = 4;
  localparam int NV    = 3;
  localparam int PI_W  = 2;
  localparam int PO_W  = 2;
  localparam int CNT_W = 4;
  localparam int TOTAL = (NV + 2) * L + NV + 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, flip_so = 1'b0, flip_po = 1'b0;
  logic scan_en, chain_si, chain_so, done, pass;
  logic [PI_W-1:0]  pi_drv;
  logic [PO_W-1:0]  po_obs;
  logic [CNT_W-1:0] mismatch_cnt;
  logic [L-1:0]     cells;

  int total_chk = 0;
  int bad_chk   = 0;

  always #5 clk = ~clk;

  scan_seq_ctrl #(
    .CHAIN_LEN(L), .NUM_VEC(NV), .PI_W(PI_W), .PO_W(PO_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .chain_so(chain_so), .po_obs(po_obs),
    .scan_en(scan_en), .chain_si(chain_si), .pi_drv(pi_drv),
    .done(done), .pass(pass), .mismatch_cnt(mismatch_cnt)
  );

  scan_cut_model #(.CHAIN_LEN(L), .PI_W(PI_W), .PO_W(PO_W)) u_cut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .si(chain_si), .pi(pi_drv),
    .flip_so(flip_so), .flip_po(flip_po), .so(chain_so), .po(po_obs), .cells(cells)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // so_mode: 0 none, 1 flush cycles only, 2 after flush only, 3 always
  task automatic run_seq(input int so_mode, input bit poke,
                         output int cyc, output int sm, output int caps,
                         output int bad_pi, output int bad_st,
                         output int bad_shpi, output int bad_fl);
    cyc = 0; sm = 0; caps = 0; bad_pi = 0; bad_st = 0; bad_shpi = 0; bad_fl = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cyc < 1000) begin
      flip_so = (so_mode == 3) || (so_mode == 1 && cyc < L + 4) ||
                (so_mode == 2 && cyc >= L + 4);
      if (cyc < L + 4 && chain_si != (((cyc % 4) >= 2) ? 1'b1 : 1'b0)) bad_fl++;
      if (scan_en) begin
        sm++;
        if (pi_drv != '0) bad_shpi++;
      end else begin
        if (int'(pi_drv) != (2 * caps + 1) % (1 << PI_W)) bad_pi++;
        if (int'(cells) != (5 * caps + 3) % (1 << L)) bad_st++;
        caps++;
      end
      if (poke && cyc == 10) start = 1'b1;
      if (poke && cyc == 11) start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    flip_so = 1'b0;
    if (cyc >= 1000) chk(1'b0, "watchdog run", cyc, TOTAL);
  endtask

  task automatic check_shape(input string nm, input int cyc, input int sm, input int caps,
                             input int bad_pi, input int bad_st, input int bad_shpi,
                             input int bad_fl);
    chk(cyc == TOTAL, {"R6 length ", nm}, cyc, TOTAL);
    chk(sm == TOTAL - NV, {"R6 scan cycles ", nm}, sm, TOTAL - NV);
    chk(caps == NV, {"R3 captures ", nm}, caps, NV);
    chk(bad_pi == 0, {"R3 capture inputs ", nm}, bad_pi, 0);
    chk(bad_st == 0, {"R3 loaded state ", nm}, bad_st, 0);
    chk(bad_shpi == 0, {"R7 inputs zero in shift ", nm}, bad_shpi, 0);
    chk(bad_fl == 0, {"R1 flush pattern ", nm}, bad_fl, 0);
  endtask

  initial begin
    #2_000_000;
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    int cyc, sm, caps, bpi, bst, bsh, bfl;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!scan_en && !chain_si && !done && !pass && mismatch_cnt == '0,
        "R11 reset outputs", int'({scan_en, chain_si, done, pass}), 0);
    repeat (5) @(negedge clk);
    chk(!scan_en && !done, "R11 idle without start", int'({scan_en, done}), 0);

    // clean run
    run_seq(0, 1'b0, cyc, sm, caps, bpi, bst, bsh, bfl);
    check_shape("clean", cyc, sm, caps, bpi, bst, bsh, bfl);
    chk(int'(mismatch_cnt) == 0, "R2 R4 R5 clean count", int'(mismatch_cnt), 0);
    chk(pass == 1'b1, "R8 pass clean", int'(pass), 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8 done held", int'(done), 1);
    chk(scan_en == 1'b0, "R7 scan off when done", int'(scan_en), 0);

    // primary-output fault: one mismatch per capture
    flip_po = 1'b1;
    run_seq(0, 1'b0, cyc, sm, caps, bpi, bst, bsh, bfl);
    flip_po = 1'b0;
    chk(int'(mismatch_cnt) == NV, "R4 output fault count", int'(mismatch_cnt), NV);
    chk(pass == 1'b0, "R8 pass low on fault", int'(pass), 0);

    // scan-out fault in flush only: CHAIN_LEN+4-CHAIN_LEN compared cycles
    run_seq(1, 1'b0, cyc, sm, caps, bpi, bst, bsh, bfl);
    chk(int'(mismatch_cnt) == 4, "R2 flush compare count", int'(mismatch_cnt), 4);

    // scan-out fault after flush only: NV*L compared bits
    run_seq(2, 1'b0, cyc, sm, caps, bpi, bst, bsh, bfl);
    chk(int'(mismatch_cnt) == NV * L, "R5 unload compare count", int'(mismatch_cnt), NV * L);

    // scan-out fault everywhere: 4+NV*L exceeds CMAX, so the count saturates
    run_seq(3, 1'b0, cyc, sm, caps, bpi, bst, bsh, bfl);
    chk(int'(mismatch_cnt) == CMAX, "R9 saturation", int'(mismatch_cnt),
        (4 + NV * L > CMAX) ? CMAX : 4 + NV * L);

    // clean run with a start poke mid-sequence
    run_seq(0, 1'b1, cyc, sm, caps, bpi, bst, bsh, bfl);
    check_shape("poked", cyc, sm, caps, bpi, bst, bsh, bfl);
    chk(cyc == TOTAL, "R10 start ignored while running", cyc, TOTAL);
    chk(int'(mismatch_cnt) == 0, "R9 cleared by start", int'(mismatch_cnt), 0);
    chk(pass == 1'b1 && done == 1'b1, "R8 pass after rerun", int'({done, pass}), 3);

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule